// File: doc/BRIEF.md
# Wiegand Two-Line Receiver with Register Readout

This block receives frames from a two-wire card reader link. Both lines rest high. The transmitter sends each bit as a short low pulse. A pulse on the zero line carries a 0 and a pulse on the one line carries a 1. The lines are brought into the clock domain by a chain of synchroniser flops. The falling edge of a line shifts one bit into a capture register that holds up to 64 bits, and a counter tracks how many bits have arrived. The link has no length field. A frame ends when both lines have stayed high for a programmable number of cycles after the last bit.

Software reads the frame through a small 32-bit slave port with a 6-bit word address. Each request raised with cyc and stb gets exactly one reply in the following cycle: ack, err or rty. A read of the data words before a frame has closed is answered with rty, which tells the host to poll again later. A read of the status word returns the done flag, the sticky error flag and the bit count. If the frame was done, that read also clears the frame and arms capture for the next one. The port has no streaming data path, so no valid/ready back-pressure applies. The host holds at most one request open and drops stb once it has seen a reply.

Top module: `wgd_rx_top`

## Requirements
- R1: After reset, no reply line is high. The status word (address 2) reads 0. The timeout word (address 3) reads the reset value TMO_INIT (64 by default).
- R2: A low pulse on the zero line records a 0 and a low pulse on the one line records a 1. The newest bit lands in bit 0 of word 0 (address 0) and earlier bits move up, crossing into word 1 (address 1).
- R3: The bit count sits in status bits [14:8] and stops at 64. Bits beyond 64 keep shifting, so the oldest bit leaves from bit 63.
- R4: The done flag (status bit 0) rises only after at least one bit has arrived and both lines have then stayed high for the number of cycles held in the timeout word. A short gap leaves it low.
- R5: While done is high, further pulses change neither the data words nor the count.
- R6: Both lines low together sets the sticky error flag (status bit 1). A fall on one line while the other is already low records no bit. Any status read clears the flag.
- R7: A status read returns the values from before the read. If done was high, the read then clears done, the count and the data, and capture starts again.
- R8: A data word read is answered with ack and the word if done is high, and with rty and no data if done is low.
- R9: A request raised with cyc and stb gets exactly one of ack, err or rty, one cycle later, and each reply lasts one cycle. Nothing replies without a request.
- R10: A write to address 3 loads its low 16 bits into the timeout and is acked. A write to addresses 0 to 2, and any access above address 3, is answered with err.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| zero_n_i | input | 1 | Zero data line, active low, asynchronous |
| one_n_i | input | 1 | One data line, active low, asynchronous |
| adr_i | input | 6 | Word address |
| dat_i | input | 32 | Write data |
| dat_o | output | 32 | Read data, valid with ack |
| cyc_i | input | 1 | Bus cycle in progress |
| stb_i | input | 1 | Request strobe |
| we_i | input | 1 | Write enable |
| ack_o | output | 1 | Request done |
| err_o | output | 1 | Request refused |
| rty_o | output | 1 | Retry later: frame not yet closed |

## Verification
The bench sends frames of every length from 1 to 70 bits, with a different bit pattern for each length. It computes the expected words and count by shifting a model register. A wrong shift direction or a wrong edge decode changes the data words at the first frame that is read. A count that does not saturate shows up at frame 65.

A timeout that is compared wrongly does not stay hidden. Either done is already set at the early status read two cycles after the last pulse, or data reads still get rty well after the idle window. A re-arm that fails to clear state shows in the status read that follows every frame. A misrouted reply shows on the very request that caused it.

// File: rtl/wgd_pkg.sv
package wgd_pkg;
  // Reply kind held by the slave port for one cycle
  typedef enum logic [1:0] {
    RSP_NONE = 2'd0,
    RSP_ACK  = 2'd1,
    RSP_ERR  = 2'd2,
    RSP_RTY  = 2'd3
  } rsp_e;

  // Bit position of the count field inside the status word
  localparam int unsigned ST_CNT_LSB = 8;
endpackage

// File: rtl/wgd_sync.sv
// Synchroniser chain for a group of idle-high asynchronous lines
module wgd_sync #(
  parameter int unsigned LINES  = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [LINES-1:0] async_i,
  output logic [LINES-1:0] sync_o
);
  logic [LINES-1:0] stg [STAGES];

  always_ff @(posedge clk) begin
    if (rst) stg[0] <= '1;
    else     stg[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk) begin
      if (rst) stg[s] <= '1;
      else     stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/wgd_capture.sv
// Edge decode, bit shift register, count and idle timeout
module wgd_capture #(
  parameter int unsigned MAX_BITS = 64,
  parameter int unsigned TMO_W    = 16,
  parameter int unsigned CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                zero_s,
  input  logic                one_s,
  input  logic                rearm,
  input  logic                clr_err,
  input  logic [TMO_W-1:0]    tmo,
  output logic [MAX_BITS-1:0] shreg,
  output logic [CNT_W-1:0]    bit_cnt,
  output logic                done,
  output logic                err_flag
);
  logic             zero_q, one_q;
  logic [TMO_W-1:0] idle_cnt;
  logic             fall0, fall1, clash, take, quiet, expire;

  assign fall0  = zero_q & ~zero_s;
  assign fall1  = one_q & ~one_s;
  assign clash  = ~zero_s & ~one_s;
  assign take   = (fall0 ^ fall1) & ~clash & ~done;
  assign quiet  = zero_s & one_s & (bit_cnt != '0);
  assign expire = ({1'b0, idle_cnt} + (TMO_W+1)'(1)) >= {1'b0, tmo};

  always_ff @(posedge clk) begin
    if (rst) begin
      zero_q   <= 1'b1;
      one_q    <= 1'b1;
      shreg    <= '0;
      bit_cnt  <= '0;
      done     <= 1'b0;
      idle_cnt <= '0;
      err_flag <= 1'b0;
    end else begin
      zero_q <= zero_s;
      one_q  <= one_s;

      if (clash)        err_flag <= 1'b1;
      else if (clr_err) err_flag <= 1'b0;

      if (rearm) begin
        shreg    <= '0;
        bit_cnt  <= '0;
        done     <= 1'b0;
        idle_cnt <= '0;
      end else if (take) begin
        shreg    <= {shreg[MAX_BITS-2:0], fall1};
        if (bit_cnt != CNT_W'(MAX_BITS)) bit_cnt <= bit_cnt + CNT_W'(1);
        idle_cnt <= '0;
      end else if (!done) begin
        if (!quiet) begin
          idle_cnt <= '0;
        end else if (expire) begin
          done     <= 1'b1;
          idle_cnt <= '0;
        end else begin
          idle_cnt <= idle_cnt + TMO_W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/wgd_bus_slv.sv
// Register slave: data words, status with read side effects, timeout word
module wgd_bus_slv
  import wgd_pkg::*;
#(
  parameter int unsigned MAX_BITS = 64,
  parameter int unsigned BUS_W    = 32,
  parameter int unsigned ADR_W    = 6,
  parameter int unsigned TMO_W    = 16,
  parameter int unsigned TMO_INIT = 64,
  parameter int unsigned CNT_W    = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADR_W-1:0]    adr_i,
  input  logic [BUS_W-1:0]    dat_i,
  input  logic                cyc_i,
  input  logic                stb_i,
  input  logic                we_i,
  input  logic [MAX_BITS-1:0] shreg,
  input  logic [CNT_W-1:0]    bit_cnt,
  input  logic                done,
  input  logic                err_flag,
  output logic [BUS_W-1:0]    dat_o,
  output logic                ack_o,
  output logic                err_o,
  output logic                rty_o,
  output logic                rearm,
  output logic                clr_err,
  output logic [TMO_W-1:0]    tmo
);
  localparam int unsigned NWORDS  = MAX_BITS / BUS_W;
  localparam int unsigned ST_ADR  = NWORDS;
  localparam int unsigned TMO_ADR = NWORDS + 1;

  logic [BUS_W-1:0] word_arr [NWORDS];
  logic [BUS_W-1:0] sel_word, status_w;
  rsp_e             rsp_q;
  logic             req;
  logic             unused_wbits;

  for (genvar w = 0; w < NWORDS; w++) begin : g_word
    assign word_arr[w] = shreg[w*BUS_W +: BUS_W];
  end

  always_comb begin
    sel_word = '0;
    for (int w = 0; w < NWORDS; w++) begin
      if (adr_i == ADR_W'(w)) sel_word = word_arr[w];
    end
  end

  always_comb begin
    status_w                         = '0;
    status_w[0]                      = done;
    status_w[1]                      = err_flag;
    status_w[ST_CNT_LSB +: CNT_W]    = bit_cnt;
  end

  assign req          = cyc_i & stb_i & (rsp_q == RSP_NONE);
  assign unused_wbits = ^dat_i[BUS_W-1:TMO_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      rsp_q   <= RSP_NONE;
      dat_o   <= '0;
      rearm   <= 1'b0;
      clr_err <= 1'b0;
      tmo     <= TMO_W'(TMO_INIT);
    end else begin
      rsp_q   <= RSP_NONE;
      dat_o   <= '0;
      rearm   <= 1'b0;
      clr_err <= 1'b0;
      if (req) begin
        if (adr_i < ADR_W'(NWORDS)) begin
          if (we_i)       rsp_q <= RSP_ERR;
          else if (!done) rsp_q <= RSP_RTY;
          else begin
            rsp_q <= RSP_ACK;
            dat_o <= sel_word;
          end
        end else if (adr_i == ADR_W'(ST_ADR)) begin
          if (we_i) rsp_q <= RSP_ERR;
          else begin
            rsp_q   <= RSP_ACK;
            dat_o   <= status_w;
            clr_err <= 1'b1;
            rearm   <= done;
          end
        end else if (adr_i == ADR_W'(TMO_ADR)) begin
          rsp_q <= RSP_ACK;
          if (we_i) tmo   <= dat_i[TMO_W-1:0];
          else      dat_o <= BUS_W'(tmo);
        end else begin
          rsp_q <= RSP_ERR;
        end
      end
    end
  end

  assign ack_o = (rsp_q == RSP_ACK);
  assign err_o = (rsp_q == RSP_ERR);
  assign rty_o = (rsp_q == RSP_RTY);
endmodule

// File: rtl/wgd_rx_top.sv
module wgd_rx_top #(
  parameter int unsigned MAX_BITS    = 64,
  parameter int unsigned BUS_W       = 32,
  parameter int unsigned ADR_W       = 6,
  parameter int unsigned TMO_W       = 16,
  parameter int unsigned TMO_INIT    = 64,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             zero_n_i,
  input  logic             one_n_i,
  input  logic [ADR_W-1:0] adr_i,
  input  logic [BUS_W-1:0] dat_i,
  output logic [BUS_W-1:0] dat_o,
  input  logic             cyc_i,
  input  logic             stb_i,
  input  logic             we_i,
  output logic             ack_o,
  output logic             err_o,
  output logic             rty_o
);
  localparam int unsigned CNT_W = $clog2(MAX_BITS + 1);

  logic [1:0]          lines_s;
  logic                zero_s, one_s;
  logic [MAX_BITS-1:0] shreg;
  logic [CNT_W-1:0]    bit_cnt;
  logic                done, err_flag, rearm, clr_err;
  logic [TMO_W-1:0]    tmo;

  wgd_sync #(.LINES(2), .STAGES(SYNC_STAGES)) sync_i (
    .clk(clk), .rst(rst),
    .async_i({one_n_i, zero_n_i}),
    .sync_o(lines_s)
  );
  assign zero_s = lines_s[0];
  assign one_s  = lines_s[1];

  wgd_capture #(.MAX_BITS(MAX_BITS), .TMO_W(TMO_W), .CNT_W(CNT_W)) cap_i (
    .clk(clk), .rst(rst), .zero_s(zero_s), .one_s(one_s),
    .rearm(rearm), .clr_err(clr_err), .tmo(tmo),
    .shreg(shreg), .bit_cnt(bit_cnt), .done(done), .err_flag(err_flag)
  );

  wgd_bus_slv #(.MAX_BITS(MAX_BITS), .BUS_W(BUS_W), .ADR_W(ADR_W),
                .TMO_W(TMO_W), .TMO_INIT(TMO_INIT), .CNT_W(CNT_W)) slv_i (
    .clk(clk), .rst(rst), .adr_i(adr_i), .dat_i(dat_i),
    .cyc_i(cyc_i), .stb_i(stb_i), .we_i(we_i),
    .shreg(shreg), .bit_cnt(bit_cnt), .done(done), .err_flag(err_flag),
    .dat_o(dat_o), .ack_o(ack_o), .err_o(err_o), .rty_o(rty_o),
    .rearm(rearm), .clr_err(clr_err), .tmo(tmo)
  );
endmodule

// File: rtl/wgd_rx_chk.sv
module wgd_rx_chk #(
  parameter int unsigned MAX_BITS = 64,
  parameter int unsigned CNT_W    = $clog2(MAX_BITS + 1)
) (
  input logic             clk,
  input logic             rst,
  input logic             cyc_i,
  input logic             stb_i,
  input logic             ack_o,
  input logic             err_o,
  input logic             rty_o,
  input logic             zero_s,
  input logic             one_s,
  input logic             done,
  input logic             err_flag,
  input logic             rearm,
  input logic [CNT_W-1:0] bit_cnt
);
  AST_ONE_REPLY: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ack_o, err_o, rty_o})); // R9
  AST_REPLY_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    (ack_o || err_o || rty_o) |=> !(ack_o || err_o || rty_o)); // R9
  AST_NO_UNASKED_REPLY: assert property (@(posedge clk) disable iff (rst)
    !(cyc_i && stb_i) |=> !(ack_o || err_o || rty_o)); // R9
  AST_CNT_LIMIT: assert property (@(posedge clk) disable iff (rst)
    bit_cnt <= CNT_W'(MAX_BITS)); // R3
  AST_DONE_HELD: assert property (@(posedge clk) disable iff (rst)
    (done && !rearm) |=> done); // R5
  AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!zero_s && !one_s) |=> err_flag); // R6
  AST_RTY_ONLY_OPEN: assert property (@(posedge clk) disable iff (rst)
    rty_o |-> !$past(done)); // R8
  AST_REARM_CLEARS: assert property (@(posedge clk) disable iff (rst)
    rearm |=> (!done && bit_cnt == '0)); // R7
endmodule

bind wgd_rx_top wgd_rx_chk #(.MAX_BITS(MAX_BITS), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .cyc_i(cyc_i), .stb_i(stb_i),
  .ack_o(ack_o), .err_o(err_o), .rty_o(rty_o),
  .zero_s(zero_s), .one_s(one_s), .done(done), .err_flag(err_flag),
  .rearm(rearm), .bit_cnt(bit_cnt)
);

// File: tb/wgd_rx_top_tb_top.sv
module wgd_rx_top_tb_top;
  localparam int T_IDLE = 20;
  localparam int K_NONE = 0, K_ACK = 1, K_ERR = 2, K_RTY = 3;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        zero_n = 1'b1, one_n = 1'b1;
  logic [5:0]  adr = '0;
  logic [31:0] wdat = '0;
  logic [31:0] rdat;
  logic        cyc = 1'b0, stb = 1'b0, we = 1'b0;
  logic        ack, err, rty;
  int          n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  wgd_rx_top dut_i (
    .clk(clk), .rst(rst), .zero_n_i(zero_n), .one_n_i(one_n),
    .adr_i(adr), .dat_i(wdat), .dat_o(rdat),
    .cyc_i(cyc), .stb_i(stb), .we_i(we),
    .ack_o(ack), .err_o(err), .rty_o(rty)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic bus(input logic w, input logic [5:0] a, input logic [31:0] d,
                     output int kind, output logic [31:0] q);
    @(negedge clk);
    adr = a; wdat = d; we = w; cyc = 1'b1; stb = 1'b1;
    @(negedge clk);
    kind = ack ? K_ACK : err ? K_ERR : rty ? K_RTY : K_NONE;
    q = rdat;
    cyc = 1'b0; stb = 1'b0; we = 1'b0; adr = '0; wdat = '0;
  endtask

  task automatic pulse(input logic b, input int pw, input int gap);
    @(negedge clk);
    if (b) one_n = 1'b0; else zero_n = 1'b0;
    repeat (pw) @(negedge clk);
    one_n = 1'b1; zero_n = 1'b1;
    repeat (gap) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (190000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    int k; logic [31:0] q; logic [63:0] exp; int ecnt;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 reply idle", {ack, err, rty}, 0);
    bus(0, 6'd2, 0, k, q);
    chk("R1 status kind", k, K_ACK);
    chk("R1 status zero", q, 0);
    bus(0, 6'd3, 0, k, q);
    chk("R1 timeout init", q, 64);
    bus(1, 6'd3, T_IDLE, k, q);
    chk("R10 timeout write ack", k, K_ACK);
    bus(0, 6'd3, 0, k, q);
    chk("R10 timeout readback", q, T_IDLE);
    bus(1, 6'd0, 32'h5, k, q);
    chk("R10 write word0 err", k, K_ERR);
    bus(1, 6'd2, 32'h1, k, q);
    chk("R10 write status err", k, K_ERR);
    bus(0, 6'd40, 0, k, q);
    chk("R10 unmapped err", k, K_ERR);
    bus(0, 6'd0, 0, k, q);
    chk("R8 idle read rty", k, K_RTY);
    chk("R8 rty no data", q, 0);

    for (int n = 1; n <= 70; n++) begin
      exp = '0;
      for (int i = 0; i < n; i++) begin
        logic b;
        b = 1'(((n * 13 + i * i * 5 + i) >> 2) & 1);
        exp = {exp[62:0], b};
        pulse(b, 2 + (n % 3), (i == n - 1) ? 0 : 3 + (n % 4));
      end
      ecnt = (n > 64) ? 64 : n;
      repeat (2) @(negedge clk);
      bus(0, 6'd2, 0, k, q);
      chk("R4 not done early", q[0], 0);
      chk("R3 count early", q[14:8], ecnt);
      bus(0, 6'd0, 0, k, q);
      chk("R8 open frame rty", k, K_RTY);
      repeat (T_IDLE + 6) @(negedge clk);
      if (n % 8 == 0) pulse(~exp[0], 3, 6);
      bus(0, 6'd0, 0, k, q);
      chk("R8 done read ack", k, K_ACK);
      chk((n % 8 == 0) ? "R5 word0 kept" : "R2 word0", q, exp[31:0]);
      bus(0, 6'd1, 0, k, q);
      chk("R2 word1", q, exp[63:32]);
      bus(0, 6'd2, 0, k, q);
      chk("R4 done set", q[0], 1);
      chk("R7 status pre-clear count", q[14:8], ecnt);
      chk("R6 no error", q[1], 0);
      bus(0, 6'd2, 0, k, q);
      chk("R7 rearmed status", q, 0);
    end

    // overlap of both lines
    @(negedge clk); zero_n = 1'b0;
    repeat (2) @(negedge clk); one_n = 1'b0;
    repeat (2) @(negedge clk); zero_n = 1'b1;
    repeat (2) @(negedge clk); one_n = 1'b1;
    repeat (3) @(negedge clk);
    bus(0, 6'd2, 0, k, q);
    chk("R6 error flag set", q[1], 1);
    chk("R6 only one bit", q[14:8], 1);
    bus(0, 6'd2, 0, k, q);
    chk("R6 error cleared", q[1], 0);
    repeat (T_IDLE + 6) @(negedge clk);
    bus(0, 6'd0, 0, k, q);
    chk("R6 recorded bit is zero", q, 0);
    bus(0, 6'd2, 0, k, q);
    chk("R6 frame closed", q[0], 1);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule